// File: doc/BRIEF.md
# Nine-Bit Multidrop Address Filter

This block sits behind the character deserializer of a serial receiver that runs in multidrop nine-bit mode. Every received character carries a data byte plus a ninth flag bit. When the flag is set the character is an address. When the flag is clear it is data. The filter decides, one character at a time, whether the character goes on to the receive queue.

An address character is compared against two patterns. Both patterns are derived from a station address register and a mask register. The first is the station's own address, in which cleared mask bits are ignored. The second is a broadcast address: the bits set in the OR of the two registers must all be 1 in the received byte.

An accepted address selects the station. A rejected address deselects it. While the station is selected, data characters pass through; otherwise they are dropped. With nine-bit mode switched off the filter is transparent.

Top module: `nine_bit_filter`

## Requirements
- R1: A forwarded character appears on `fwd_vld`/`fwd_char` exactly one clock after its `rx_vld` cycle. `fwd_vld` is low in every cycle that follows a clock in which `rx_vld` was low.
- R2: `rx_char` bit 8 set marks an address character. Bit 8 clear marks a data character. Bits 7:0 are the payload, and the forwarded character keeps all 9 bits unchanged.
- R3: Own-address match: for every bit n with `cfg_mask[n]`=1, payload bit n must equal `cfg_addr[n]`. Bits with `cfg_mask[n]`=0 are ignored.
- R4: Broadcast match: for every bit n with (`cfg_addr` | `cfg_mask`)[n]=1, payload bit n must be 1. All other bits are ignored.
- R5: In nine-bit mode, an address character that meets R3 or R4 is forwarded and sets the selected state. An address character that meets neither is dropped and clears the selected state.
- R6: In nine-bit mode, a data character is forwarded if and only if the selected state is set. Data characters do not change the selected state.
- R7: After reset the selected state is clear and `fwd_vld` is low, so data received before any address is dropped.
- R8: With `mode_en` low, every valid character is forwarded unchanged, whatever its flag bit. The selected state is cleared while `mode_en` is low, so data that arrives right after mode is re-enabled is dropped.
- R9: Example: with address 11110100 and mask 01010101, the own pattern is x1x1x1x0 and the broadcast pattern is 1111x1x1. With address 11100111 and mask 00001111, the patterns are xxxx0111 and 111x1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Nine-bit filtering enable |
| cfg_addr | input | 8 | Station address register |
| cfg_mask | input | 8 | Station address mask register |
| rx_vld | input | 1 | Received character strobe |
| rx_char | input | 9 | Received character, bit 8 is the address flag |
| fwd_vld | output | 1 | Forwarded character strobe |
| fwd_char | output | 9 | Forwarded character |

## Verification
The bench builds the filter with its default payload width of 8 bits. At that width, every one of the 256 possible address bytes can be sent against each of several address and mask configurations, including those of R9 and the all-ones and all-zeros masks. After each address, a data character shows whether the selected state was set or cleared. Expected results come from a per-bit model of the two match rules. Separate phases cover reset, bypass with mode disabled, and re-enabling mode.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

  // Disposition of one received character
  typedef enum logic [1:0] {
    ACT_DROP      = 2'd0,
    ACT_PASS_DATA = 2'd1,
    ACT_PASS_ADDR = 2'd2,
    ACT_BYPASS    = 2'd3
  } act_e;

  function automatic logic act_forwards(input act_e a);
    return a != ACT_DROP;
  endfunction

endpackage

// File: rtl/nbm_addr_match.sv
module nbm_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic [DATA_W-1:0] rx_data,
  output logic              given_hit,
  output logic              bcast_hit,
  output logic              any_hit
);

  logic [DATA_W-1:0] given_bit_ok;
  logic [DATA_W-1:0] bcast_bit_ok;
  logic [DATA_W-1:0] bcast_req;

  // bits that must read as 1 for a broadcast
  assign bcast_req = cfg_addr | cfg_mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // masked-out bit, or equal to the station address bit
    assign given_bit_ok[i] = ~cfg_mask[i] | (rx_data[i] ~^ cfg_addr[i]);
    // not required, or received as 1
    assign bcast_bit_ok[i] = ~bcast_req[i] | rx_data[i];
  end

  assign given_hit = &given_bit_ok;
  assign bcast_hit = &bcast_bit_ok;
  assign any_hit   = given_hit | bcast_hit;

  AST_GIVEN_FULLMASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cfg_mask) && given_hit) |-> (rx_data == cfg_addr)); // R3
  AST_BCAST_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ((&bcast_req) && bcast_hit) |-> (&rx_data)); // R4

endmodule

// File: rtl/nbm_sel_tracker.sv
module nbm_sel_tracker
  import nbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic rx_vld,
  input  logic rx_flag,
  input  logic addr_hit,
  output logic sel_q,
  output act_e act,
  output logic pass
);

  logic sel_d;

  always_comb begin
    act = ACT_DROP;
    if (rx_vld) begin
      if (!mode_en)     act = ACT_BYPASS;
      else if (rx_flag) act = addr_hit ? ACT_PASS_ADDR : ACT_DROP;
      else              act = sel_q ? ACT_PASS_DATA : ACT_DROP;
    end
  end

  assign pass = act_forwards(act);

  always_comb begin
    sel_d = sel_q;
    if (!mode_en)               sel_d = 1'b0;
    else if (rx_vld && rx_flag) sel_d = addr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  AST_DATA_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && rx_vld && !rx_flag) |=> (sel_q == $past(sel_q))); // R6
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_en) |=> !sel_q); // R8

endmodule

// File: rtl/nbm_out_stage.sv
module nbm_out_stage #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass,
  input  logic [CHAR_W-1:0] in_char,
  output logic              out_vld,
  output logic [CHAR_W-1:0] out_char
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_char <= '0;
    end else begin
      out_vld <= pass;
      if (pass) out_char <= in_char;
    end
  end

endmodule

// File: rtl/nine_bit_filter.sv
module nine_bit_filter
  import nbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic [DATA_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              rx_vld,
  input  logic [DATA_W:0]   rx_char,
  output logic              fwd_vld,
  output logic [DATA_W:0]   fwd_char
);

  localparam int CHAR_W = DATA_W + 1;
  localparam int FLAG_B = DATA_W;

  logic rx_flag;
  logic given_hit, bcast_hit, any_hit;
  logic sel_q, pass;
  act_e act;

  assign rx_flag = rx_char[FLAG_B];

  nbm_addr_match #(.DATA_W(DATA_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_addr (cfg_addr),
    .cfg_mask (cfg_mask),
    .rx_data  (rx_char[DATA_W-1:0]),
    .given_hit(given_hit),
    .bcast_hit(bcast_hit),
    .any_hit  (any_hit)
  );

  nbm_sel_tracker u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_en (mode_en),
    .rx_vld  (rx_vld),
    .rx_flag (rx_flag),
    .addr_hit(any_hit),
    .sel_q   (sel_q),
    .act     (act),
    .pass    (pass)
  );

  nbm_out_stage #(.CHAR_W(CHAR_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .pass    (pass),
    .in_char (rx_char),
    .out_vld (fwd_vld),
    .out_char(fwd_char)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |=> !fwd_vld); // R1
  AST_BYPASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !mode_en) |=> (fwd_vld && fwd_char == $past(rx_char))); // R8
  AST_DATA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && rx_vld && !rx_flag && !sel_q) |=> !fwd_vld); // R6
  AST_ADDR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && rx_vld && rx_flag) |=> (sel_q == $past(given_hit || bcast_hit))); // R5
  AST_ADDR_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && rx_vld && rx_flag && !any_hit) |=> !fwd_vld); // R5

endmodule

// File: tb/tb_nine_bit_filter.sv
module tb_nine_bit_filter;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_en = 1'b0;
  logic [DATA_W-1:0] cfg_addr = '0;
  logic [DATA_W-1:0] cfg_mask = '0;
  logic              rx_vld = 1'b0;
  logic [DATA_W:0]   rx_char = '0;
  logic              fwd_vld;
  logic [DATA_W:0]   fwd_char;

  int checks = 0;
  int errors = 0;
  bit model_sel = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nine_bit_filter #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
    .rx_vld(rx_vld), .rx_char(rx_char),
    .fwd_vld(fwd_vld), .fwd_char(fwd_char)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // own-address rule restated bit by bit (R3)
  function automatic bit ref_given(input logic [7:0] a, input logic [7:0] m, input logic [7:0] r);
    for (int n = 0; n < 8; n++)
      if (m[n] == 1'b1 && r[n] != a[n]) return 1'b0;
    return 1'b1;
  endfunction

  // broadcast rule restated bit by bit (R4)
  function automatic bit ref_bcast(input logic [7:0] a, input logic [7:0] m, input logic [7:0] r);
    for (int n = 0; n < 8; n++)
      if ((a[n] == 1'b1 || m[n] == 1'b1) && r[n] == 1'b0) return 1'b0;
    return 1'b1;
  endfunction

  // drive one character at a negedge, observe the result at the next negedge
  task automatic send(input logic [8:0] ch, input bit exp_vld, input string req);
    rx_vld  = 1'b1;
    rx_char = ch;
    @(negedge clk);
    rx_vld = 1'b0;
    chk(fwd_vld == exp_vld, req, fwd_vld, exp_vld);
    if (exp_vld) chk(fwd_char == ch, req, fwd_char, ch);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(fwd_vld == 1'b0, "R1", fwd_vld, 0);
  endtask

  logic [7:0] ca [6] = '{8'hF4, 8'h0F, 8'h55, 8'hE7, 8'h00, 8'hFF};
  logic [7:0] cm [6] = '{8'h55, 8'hAA, 8'hFF, 8'h0F, 8'h00, 8'hFF};

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(fwd_vld == 1'b0, "R7", fwd_vld, 0);
    rst_n = 1'b1;
    mode_en = 1'b1;
    cfg_addr = 8'h12;
    cfg_mask = 8'hFF;
    @(negedge clk);
    chk(fwd_vld == 1'b0, "R7", fwd_vld, 0);
    send(9'h033, 1'b0, "R7");   // data before any address: dropped
    idle_check();

    // R9 spot points: 0x54 fits x1x1x1x0, 0xF5 fits 1111x1x1, 0x55 fits neither
    cfg_addr = 8'hF4; cfg_mask = 8'h55;
    send(9'h154, 1'b1, "R9");
    send(9'h1F5, 1'b1, "R9");
    send(9'h155, 1'b0, "R9");
    cfg_addr = 8'hE7; cfg_mask = 8'h0F;
    send(9'h1A7, 1'b1, "R9");   // xxxx0111
    send(9'h1EF, 1'b1, "R9");   // 111x1111
    send(9'h1E6, 1'b0, "R9");

    // exhaustive sweep per configuration (R2..R6)
    for (int c = 0; c < 6; c++) begin
      cfg_addr = ca[c];
      cfg_mask = cm[c];
      for (int r = 0; r < 256; r++) begin
        bit g, b, hit;
        g = ref_given(ca[c], cm[c], r[7:0]);
        b = ref_bcast(ca[c], cm[c], r[7:0]);
        hit = g | b;
        send({1'b1, r[7:0]}, hit, hit ? (g ? "R3" : "R4") : "R5");
        model_sel = hit;
        send({1'b0, r[7:0] ^ 8'hA5}, model_sel, "R6");
      end
      idle_check();
    end

    // bypass with mode off (R8), flagged and plain characters
    mode_en = 1'b0;
    cfg_addr = 8'h00; cfg_mask = 8'hFF;
    send(9'h1C3, 1'b1, "R8");
    send(9'h0C3, 1'b1, "R8");
    send(9'h100, 1'b1, "R8");
    send(9'h07E, 1'b1, "R8");
    mode_en = 1'b1;
    send(9'h011, 1'b0, "R8");   // selection cleared while off
    send(9'h100, 1'b1, "R5");   // matching address reselects
    send(9'h011, 1'b1, "R6");
    send(9'h022, 1'b1, "R6");   // data leaves selection unchanged
    send(9'h101, 1'b0, "R5");   // non-matching address deselects
    send(9'h022, 1'b0, "R6");
    idle_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule